// File: doc/BRIEF.md
# Three-Channel Attenuating Sound Mixer

This block turns three 4-bit sound samples into one 8-bit word for a DAC. Two of the samples come from wavetable channels and one from a noise channel. Each sample is multiplied by 16. It is then scaled by its channel's own 5-bit level setting, which gives 32 gain steps of 1/32 each. The scaled values of the enabled channels are added, and the sum is clipped to the output range. The result is registered once per clock.

A CPU register port sets the three levels, a control register and a direct data byte. When every channel is disabled and both the master enable and the bypass enable are set, the direct data byte goes to the DAC unchanged. This lets software play samples without the generators. When the master enable is clear, the DAC word is held at zero.

Software is expected to keep the combined levels within range. Any sum that still exceeds the range is clipped, and a sticky flag records that clipping took place.

Top module: `snd_mix3`

## Requirements
- R1: After reset, `dac_out` is 0 and `clip_flag` is 0. All level registers, both enables and the direct byte are 0.
- R2: Register writes use `wr_addr` and `wr_data` when `wr_en` is high:
  - address 0, 1 and 2 set the level of channel 0, 1 and 2 from bits [4:0];
  - address 3 sets the master enable from bit 0 and the bypass enable from bit 1;
  - address 4 sets the direct byte;
  - writes to addresses 5 to 7 have no effect.
- R3: An enabled channel with sample `s` and level `L` contributes `(s*16*(32-L))>>5`. Level 0 passes `s*16` unchanged.
- R4: A channel whose `ch_en` bit is 0 contributes zero, whatever its sample and level.
- R5: In the mixing path, `dac_out` is the sum of the three contributions, saturated at 8'hFF.
- R6: `clip_flag` goes to 1 after any clock edge where the master enable is set, the mixing path is selected, and the raw sum exceeds 255. It then stays at 1 until reset.
- R7: When the master enable and the bypass enable are both 1 and `ch_en` is 3'b000, `dac_out` takes the direct byte unchanged.
- R8: When the master enable is 0, `dac_out` is 0 and `clip_flag` is not set.
- R9: `dac_out` follows the inputs and register values present at the clock edge. A register write therefore reaches `dac_out` one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp0 | input | 4 | Wavetable channel 0 sample |
| smp1 | input | 4 | Wavetable channel 1 sample |
| smp2 | input | 4 | Noise channel sample |
| ch_en | input | 3 | Per-channel enable, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| dac_out | output | 8 | Registered DAC input word |
| clip_flag | output | 1 | Sticky saturation indicator |

## Verification
The bench sweeps every level against every sample on each channel in isolation. A wrong gain formula, for example `L/32` instead of `(32-L)/32`, or a missing ×16, shows up at level 0 and level 31. Mixed patterns across all eight enable combinations drive the sum past 255. A mixer that wraps instead of clipping produces small values there, and a flag that is not sticky drops back to 0. The bypass is tried with one channel still enabled, which must fall back to mixing, and with the master enable cleared, which must force zero. Writes to the unused addresses are followed by a check of the output, which would reveal an address decode that aliases onto a live register.

// File: rtl/snd_mix3.sv
module snd_mix3 #(
  parameter int SW = 4,
  parameter int LW = 5,
  parameter int OW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp0,
  input  logic [SW-1:0] smp1,
  input  logic [SW-1:0] smp2,
  input  logic [2:0]    ch_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [OW-1:0] wr_data,
  output logic [OW-1:0] dac_out,
  output logic          clip_flag
);
  localparam int XW   = SW + 4;
  localparam int PW   = XW + LW + 1;
  localparam int SUMW = XW + 2;
  localparam logic [LW:0] FULL = (LW+1)'(1 << LW);

  logic [LW-1:0] lvl [3];
  logic          snd_en, byp_en;
  logic [OW-1:0] direct;
  logic [SW-1:0] smp [3];
  logic [XW-1:0] contrib [3];
  logic [SUMW-1:0] sum;
  logic          over, bypass;

  assign smp[0] = smp0;
  assign smp[1] = smp1;
  assign smp[2] = smp2;

  for (genvar g = 0; g < 3; g++) begin : g_ch
    logic [XW-1:0] x;
    logic [LW:0]   gain;
    logic [PW-1:0] prod;
    assign x    = {smp[g], 4'b0000};
    assign gain = FULL - {1'b0, lvl[g]};
    assign prod = PW'(x) * PW'(gain);
    assign contrib[g] = ch_en[g] ? XW'(prod >> LW) : '0;

    always_ff @(posedge clk)
      if (!rst_n) lvl[g] <= '0;
      else if (wr_en && wr_addr == AW'(g)) lvl[g] <= wr_data[LW-1:0];
  end

  assign sum    = SUMW'(contrib[0]) + SUMW'(contrib[1]) + SUMW'(contrib[2]);
  assign over   = |sum[SUMW-1:OW];
  assign bypass = byp_en && (ch_en == 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snd_en <= 1'b0;
      byp_en <= 1'b0;
      direct <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(3)) begin
        snd_en <= wr_data[0];
        byp_en <= wr_data[1];
      end
      if (wr_addr == AW'(4)) direct <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_out   <= '0;
      clip_flag <= 1'b0;
    end else begin
      if (!snd_en)     dac_out <= '0;
      else if (bypass) dac_out <= direct;
      else             dac_out <= over ? '1 : sum[OW-1:0];
      if (snd_en && !bypass && over) clip_flag <= 1'b1;
    end
  end

  a_r8_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_en |=> dac_out == '0);
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_en && byp_en && ch_en == 3'b000) |=> dac_out == $past(direct));
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_en && ch_en != 3'b000 && over) |=> dac_out == '1);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    clip_flag |=> clip_flag);
  a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_en && !byp_en && ch_en == 3'b000) |=> dac_out == '0);
endmodule

// File: tb/snd_mix3_test.sv
module snd_mix3_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [3:0] smp0 = 0, smp1 = 0, smp2 = 0;
  logic [2:0] ch_en = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] dac_out;
  logic clip_flag;
  int checks = 0, fails = 0;
  int lv [3];
  bit exp_clip = 0;

  snd_mix3 uut (.clk(clk), .rst_n(rst_n), .smp0(smp0), .smp1(smp1), .smp2(smp2),
    .ch_en(ch_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dac_out(dac_out), .clip_flag(clip_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*150000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    tick;
    wr_en = 0;
    if (a < 3) lv[a] = d & 31;
  endtask

  function automatic int part(int s, int l, bit en);
    return en ? (s * 16 * (32 - l)) >> 5 : 0;
  endfunction

  function automatic int mix(int s0, int s1, int s2, logic [2:0] e);
    return part(s0, lv[0], e[0]) + part(s1, lv[1], e[1]) + part(s2, lv[2], e[2]);
  endfunction

  task automatic mix_check(string req, int s0, int s1, int s2, logic [2:0] e);
    int raw;
    smp0 = 4'(s0); smp1 = 4'(s1); smp2 = 4'(s2); ch_en = e;
    raw = mix(s0, s1, s2, e);
    if (raw > 255) exp_clip = 1;
    tick;
    chk(req, dac_out, raw > 255 ? 255 : raw);
    chk("R6", clip_flag, exp_clip);
  endtask

  initial begin
    lv[0] = 0; lv[1] = 0; lv[2] = 0;
    tick; tick;
    rst_n = 1;
    chk("R1", dac_out, 0);
    chk("R1", clip_flag, 0);
    ch_en = 3'b111; smp0 = 15; smp1 = 15; smp2 = 15;
    tick;
    chk("R8", dac_out, 0);
    chk("R8", clip_flag, 0);

    wr(3, 1);
    // R9: level write at this edge, output uses it one edge later
    ch_en = 3'b001; smp0 = 10;
    wr(0, 31);
    chk("R9", dac_out, 160);
    tick;
    chk("R9", dac_out, (160 * 1) >> 5);

    // R3: every level against every sample on each channel alone
    for (int c = 0; c < 3; c++)
      for (int l = 0; l < 32; l++) begin
        wr(c, l);
        for (int s = 0; s < 16; s++)
          mix_check("R3", c == 0 ? s : 0, c == 1 ? s : 0, c == 2 ? s : 0, 3'(1 << c));
      end

    // R4/R5: mixed patterns, all enable combinations, including clipping
    wr(0, 4); wr(1, 10); wr(2, 0);
    for (int e = 0; e < 8; e++)
      for (int a = 0; a < 16; a += 5)
        for (int b = 0; b < 16; b += 5)
          for (int d = 0; d < 16; d += 5)
            mix_check(e == 7 ? "R5" : "R4", a, b, d, 3'(e));
    chk("R6", clip_flag, 1);

    // R2: unused addresses leave config unchanged
    wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    mix_check("R2", 3, 0, 0, 3'b001);
    // R7: bypass
    wr(4, 8'hA5); wr(3, 3);
    ch_en = 0;
    tick;
    chk("R7", dac_out, 8'hA5);
    ch_en = 3'b010; smp1 = 2;
    tick;
    chk("R7", dac_out, part(2, lv[1], 1));
    ch_en = 0;
    wr(4, 8'h3C);
    chk("R9", dac_out, 8'hA5);
    tick;
    chk("R7", dac_out, 8'h3C);
    wr(3, 2);
    tick;
    chk("R8", dac_out, 0);
    wr(3, 1);
    tick;
    chk("R4", dac_out, 0);
    chk("R6", clip_flag, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule